// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block watches a configurable set of asynchronous interrupt pins and turns them into one interrupt request for the processor. Every line is first brought into the clock domain by a flop chain. It then goes through a sense stage, which can be set per line to react to a rising edge, a falling edge, a high level or a low level. The result is a pending bit. A per-line mask bit gates the pending bit, and the masked bits are ORed into one request output.

Software reaches the block through a small word-addressed register bus. Three bit-vector registers select how each line is sensed. Two write-one strobe registers set and clear mask bits, and a separate register reads the mask back. A write-one register acknowledges pending bits. Lines beyond the implemented count have no storage and always read as zero. Software can therefore learn the line count by writing all ones to the sense-type register and reading it back. Deciding which line to service first is left to software.

Top module: `ext_sense_ctrl`

## Requirements
- R1: A change on a pin reaches the pending register on the (SYNC_STAGES+1)-th rising clock edge after the change, and is not visible before that edge.
- R2: A line whose sense-type bit (offset 5) is 0 is edge sensed. Its polarity bit (offset 6) set to 1 detects rising edges, and 0 detects falling edges. An edge of the other direction leaves the pending bit unchanged.
- R3: A line whose sense-type bit is 1 is level sensed. Its level bit (offset 7) set to 1 means active-high and 0 means active-low. Its pending bit follows the active state, so an acknowledge has no lasting effect while the level stays active.
- R4: An edge-sensed pending bit stays set until software writes a 1 to its bit in the acknowledge register (offset 4). Zero bits in that write leave pending bits unchanged.
- R5: Writing ones to offset 0 sets the matching mask bits, and writing ones to offset 1 clears them. Other mask bits keep their value. The mask reads back at offset 2.
- R6: The pending bits read at offset 3. irq_out is high exactly when some line is both pending and unmasked.
- R7: Register bits at or above the LINES position always read 0. Writing all ones to offset 5 and reading it back returns a value whose highest set bit is at position LINES-1.
- R8: Offsets 0, 1 and 4 are write-only and read as 0.
- R9: When an acknowledge write and a new qualifying edge on the same line occur in the same cycle, the pending bit stays set.
- R10: After reset, the mask, pending, sense-type, polarity and level registers are all 0, so every line is falling-edge sensed and irq_out is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pins | input | LINES | Asynchronous interrupt pins |
| bus_en | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 3 | Word offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational, 0 when no read is in progress |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with LINES=5, DATA_W=32 and SYNC_STAGES=2. With these values, bits 5 to 31 of a 32-bit register are unimplemented, which lets the line-count probe and the read-as-zero rule be checked on real upper bits. With a two-stage chain, the latency check and the acknowledge-versus-edge collision can be hit on an exact edge. Five lines are enough for random sense-type mixes to put edge and level lines side by side in the same register words.

// File: rtl/eisc_pkg.sv
package eisc_pkg;
   localparam int unsigned OFS_W = 3;

   typedef enum logic [OFS_W-1:0] {
      OFS_ARM    = 3'd0,
      OFS_DISARM = 3'd1,
      OFS_MASK   = 3'd2,
      OFS_PEND   = 3'd3,
      OFS_ACK    = 3'd4,
      OFS_MODE   = 3'd5,
      OFS_EDGE   = 3'd6,
      OFS_LEVEL  = 3'd7
   } reg_ofs_e;
endpackage

// File: rtl/eisc_sync.sv
module eisc_sync #(
   parameter int unsigned LINES  = 4,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] async_in,
   output logic [LINES-1:0] sync_out
);
   logic [STAGES-1:0][LINES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], async_in};
   end

   assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/eisc_sense.sv
module eisc_sense #(
   parameter int unsigned LINES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] sync_in,
   input  logic [LINES-1:0] lvl_mode,
   input  logic [LINES-1:0] rise_sel,
   input  logic [LINES-1:0] high_sel,
   input  logic [LINES-1:0] ack_vec,
   output logic [LINES-1:0] pend_q
);
   logic [LINES-1:0] prev_q;
   logic [LINES-1:0] pend_d;

   for (genvar i = 0; i < LINES; i++) begin : g_line
      logic active, hit;
      assign active    = (sync_in[i] == high_sel[i]);
      assign hit       = (sync_in[i] != prev_q[i]) && (sync_in[i] == rise_sel[i]);
      assign pend_d[i] = lvl_mode[i] ? active : (hit | (pend_q[i] & ~ack_vec[i]));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         pend_q <= '0;
      end else begin
         prev_q <= sync_in;
         pend_q <= pend_d;
      end
   end
endmodule

// File: rtl/eisc_regs.sv
module eisc_regs
   import eisc_pkg::*;
#(
   parameter int unsigned LINES  = 4,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_en,
   input  logic              bus_wr,
   input  logic [OFS_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [LINES-1:0]  pend_q,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [LINES-1:0]  mask_q,
   output logic [LINES-1:0]  mode_q,
   output logic [LINES-1:0]  rise_q,
   output logic [LINES-1:0]  high_q,
   output logic [LINES-1:0]  ack_vec
);
   logic             wr_go;
   logic [LINES-1:0] wbits;
   logic [LINES-1:0] rd_lines;

   assign wr_go = bus_en && bus_wr;
   assign wbits = bus_wdata[LINES-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         mode_q <= '0;
         rise_q <= '0;
         high_q <= '0;
      end else if (wr_go) begin
         case (bus_addr)
            OFS_ARM:    mask_q <= mask_q | wbits;
            OFS_DISARM: mask_q <= mask_q & ~wbits;
            OFS_MODE:   mode_q <= wbits;
            OFS_EDGE:   rise_q <= wbits;
            OFS_LEVEL:  high_q <= wbits;
            default:    ;
         endcase
      end
   end

   assign ack_vec = (wr_go && bus_addr == OFS_ACK) ? wbits : '0;

   always_comb begin
      rd_lines = '0;
      case (bus_addr)
         OFS_MASK:  rd_lines = mask_q;
         OFS_PEND:  rd_lines = pend_q;
         OFS_MODE:  rd_lines = mode_q;
         OFS_EDGE:  rd_lines = rise_q;
         OFS_LEVEL: rd_lines = high_q;
         default:   rd_lines = '0;
      endcase
      bus_rdata = '0;
      if (bus_en && !bus_wr) bus_rdata = DATA_W'(rd_lines);
   end
endmodule

// File: rtl/ext_sense_ctrl.sv
module ext_sense_ctrl
   import eisc_pkg::*;
#(
   parameter int unsigned LINES       = 5,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LINES-1:0]  ext_pins,
   input  logic              bus_en,
   input  logic              bus_wr,
   input  logic [OFS_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_out
);
   if (LINES < 1 || LINES > DATA_W) begin : g_bad_lines
      $error("LINES must be between 1 and DATA_W");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [LINES-1:0] sync_pins;
   logic [LINES-1:0] mask_q, mode_q, rise_q, high_q, ack_vec, pend_q;

   eisc_sync #(.LINES(LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_in(ext_pins), .sync_out(sync_pins)
   );

   eisc_sense #(.LINES(LINES)) u_sense (
      .clk(clk), .rst_n(rst_n), .sync_in(sync_pins), .lvl_mode(mode_q),
      .rise_sel(rise_q), .high_sel(high_q), .ack_vec(ack_vec), .pend_q(pend_q)
   );

   eisc_regs #(.LINES(LINES), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pend_q(pend_q),
      .bus_rdata(bus_rdata), .mask_q(mask_q), .mode_q(mode_q),
      .rise_q(rise_q), .high_q(high_q), .ack_vec(ack_vec)
   );

   assign irq_out = |(pend_q & mask_q);
endmodule

// File: rtl/eisc_checker.sv
module eisc_checker #(
   parameter int unsigned LINES  = 5,
   parameter int unsigned DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_en,
   input logic              bus_wr,
   input logic [2:0]        bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              irq_out,
   input logic [LINES-1:0]  mask_q,
   input logic [LINES-1:0]  pend_q,
   input logic [LINES-1:0]  mode_q
);
   logic [LINES-1:0] wlow;
   logic             ack_go;
   assign wlow   = bus_wdata[LINES-1:0];
   assign ack_go = bus_en && bus_wr && bus_addr == 3'd4;

   AST_NOMASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (mask_q == '0) |-> !irq_out); // R6
   AST_ARM_SETS: assert property (@(posedge clk) disable iff (!rst_n) (bus_en && bus_wr && bus_addr == 3'd0) |=> ((mask_q & $past(wlow)) == $past(wlow))); // R5
   AST_DISARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (bus_en && bus_wr && bus_addr == 3'd1) |=> ((mask_q & $past(wlow)) == '0)); // R5
   AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (bus_en && !bus_wr && (bus_addr == 3'd0 || bus_addr == 3'd1 || bus_addr == 3'd4)) |-> (bus_rdata == '0)); // R8
   AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (bus_rdata >> LINES) == '0); // R7
   AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> (($past(pend_q) & ~$past(mode_q) & ~($past(ack_go) ? $past(wlow) : '0) & ~pend_q) == '0)); // R4
endmodule

bind ext_sense_ctrl eisc_checker #(.LINES(LINES), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
   .irq_out(irq_out), .mask_q(mask_q), .pend_q(pend_q), .mode_q(mode_q)
);

// File: tb/ext_sense_ctrl_test.sv
module ext_sense_ctrl_test;
   localparam int N  = 5;
   localparam int DW = 32;
   localparam int SS = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [N-1:0] ext_pins = '0;
   logic bus_en = 1'b0, bus_wr = 1'b0;
   logic [2:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic irq_out;

   int n_chk = 0, n_bad = 0;
   logic [N-1:0] m_mask = '0, m_pend = '0, m_mode = '0, m_rise = '0, m_high = '0, pins = '0;

   always #5 clk = ~clk;

   ext_sense_ctrl #(.LINES(N), .DATA_W(DW), .SYNC_STAGES(SS)) uut (
      .clk(clk), .rst_n(rst_n), .ext_pins(ext_pins), .bus_en(bus_en), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
   );

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [2:0] ofs, input logic [DW-1:0] d);
      @(negedge clk);
      bus_en = 1'b1; bus_wr = 1'b1; bus_addr = ofs; bus_wdata = d;
      @(negedge clk);
      bus_en = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic bus_read(input logic [2:0] ofs, output logic [DW-1:0] d);
      @(negedge clk);
      bus_en = 1'b1; bus_wr = 1'b0; bus_addr = ofs;
      #1 d = bus_rdata;
      bus_en = 1'b0;
   endtask

   task automatic settle();
      repeat (SS + 3) @(negedge clk);
   endtask

   function automatic logic [N-1:0] level_pend(input logic [N-1:0] p);
      logic [N-1:0] r = p;
      for (int i = 0; i < N; i++)
         if (m_mode[i]) r[i] = (pins[i] == m_high[i]);
      return r;
   endfunction

   function automatic logic [N-1:0] edge_pend(input logic [N-1:0] p, input logic [N-1:0] nv);
      logic [N-1:0] r = p;
      for (int i = 0; i < N; i++)
         if (!m_mode[i] && pins[i] != nv[i] && nv[i] == m_rise[i]) r[i] = 1'b1;
      return r;
   endfunction

   task automatic set_pins(input logic [N-1:0] v);
      m_pend = edge_pend(m_pend, v);
      pins = v;
      m_pend = level_pend(m_pend);
      @(negedge clk);
      ext_pins = v;
      settle();
   endtask

   task automatic cfg(input logic [2:0] ofs, input logic [N-1:0] v);
      bus_write(ofs, DW'(v));
      if (ofs == 3'd5) m_mode = v;
      if (ofs == 3'd6) m_rise = v;
      if (ofs == 3'd7) m_high = v;
      m_pend = level_pend(m_pend);
      settle();
   endtask

   task automatic ack(input logic [N-1:0] v);
      bus_write(3'd4, DW'(v));
      m_pend = m_pend & ~(v & ~m_mode);
      m_pend = level_pend(m_pend);
      settle();
   endtask

   task automatic arm(input logic [N-1:0] v);
      bus_write(3'd0, DW'(v));
      m_mask = m_mask | v;
   endtask

   task automatic disarm(input logic [N-1:0] v);
      bus_write(3'd1, DW'(v));
      m_mask = m_mask & ~v;
   endtask

   task automatic check_state(input string req);
      logic [DW-1:0] d;
      bus_read(3'd3, d);
      check({req, " pending"}, d, DW'(m_pend));
      check({req, " irq_out"}, DW'(irq_out), DW'(|(m_pend & m_mask)));
      bus_read(3'd2, d);
      check({req, " mask"}, d, DW'(m_mask));
   endtask

   initial begin : watchdog
      #2_000_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin : main
      logic [DW-1:0] d;
      int top;
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R10: reset values
      for (int a = 2; a < 8; a++) begin
         if (a == 4) continue;
         bus_read(3'(a), d);
         check("R10 reset register", d, '0);
      end
      check("R10 reset irq_out", DW'(irq_out), '0);

      // R5 / R8
      arm('1);
      bus_read(3'd0, d); check("R8 arm reads zero", d, '0);
      bus_read(3'd1, d); check("R8 disarm reads zero", d, '0);
      bus_read(3'd4, d); check("R8 ack reads zero", d, '0);
      bus_read(3'd2, d); check("R5 mask after arm", d, DW'(m_mask));
      disarm(5'b00101);
      bus_read(3'd2, d); check("R5 mask after partial disarm", d, DW'(m_mask));
      disarm('1);

      // R7: probe the line count
      bus_write(3'd5, '1);
      bus_read(3'd5, d);
      check("R7 mode readback", d, DW'({N{1'b1}}));
      top = 0;
      for (int i = 0; i < DW; i++) if (d[i]) top = i + 1;
      check("R7 probed line count", DW'(top), DW'(N));
      m_mode = '1; m_pend = level_pend(m_pend);
      cfg(3'd5, '0);
      ack('1);
      check_state("R4 cleared after probe");

      // R2: falling default, rising selectable
      set_pins(5'b00001);
      check_state("R2 rising ignored on falling line");
      set_pins(5'b00000);
      check_state("R2 falling detected");
      ack('0);
      check_state("R4 zero ack no effect");
      ack(5'b00001);
      check_state("R4 ack clears");
      cfg(3'd6, 5'b10010);
      set_pins(5'b00010);
      check_state("R2 rising detected");
      set_pins(5'b00000);
      check_state("R4 sticky after release");
      ack(5'b00010);

      // R3: level lines
      cfg(3'd7, 5'b00100);
      cfg(3'd5, 5'b01100);
      check_state("R3 active-low line pending");
      set_pins(5'b00100);
      check_state("R3 active-high line pending");
      ack(5'b01100);
      check_state("R3 ack no lasting effect");
      arm(5'b01000);
      check_state("R6 irq with unmasked pending");
      set_pins(5'b01000);
      check_state("R3 level lines deasserted");
      disarm(5'b01000);
      check_state("R6 irq low after disarm");

      // R1: latency on line 4 (rising)
      @(negedge clk);
      ext_pins[4] = 1'b1;
      repeat (SS - 1) @(negedge clk);
      bus_read(3'd3, d);
      check("R1 not yet pending", DW'(d[4]), '0);
      bus_read(3'd3, d);
      check("R1 pending on exact edge", DW'(d[4]), 1);
      pins[4] = 1'b1; m_pend[4] = 1'b1;
      settle();
      set_pins(pins & ~5'b10000);

      // R9: ack and new edge together
      @(negedge clk);
      ext_pins[4] = 1'b1;
      repeat (SS - 1) @(negedge clk);
      bus_write(3'd4, DW'(5'b10000));
      pins[4] = 1'b1;
      settle();
      bus_read(3'd3, d);
      check("R9 edge wins over ack", DW'(d[4]), 1);

      // Return to known state, then random phase
      set_pins('0);
      cfg(3'd5, '0);
      ack('1);
      check_state("R10 known state");
      for (int it = 0; it < 200; it++) begin
         case ($urandom_range(0, 4))
            0: set_pins(N'($urandom));
            1: arm(N'($urandom));
            2: disarm(N'($urandom));
            3: ack(N'($urandom));
            default: cfg(3'($urandom_range(5, 7)), N'($urandom));
         endcase
         check_state("R2 R3 R4 R5 R6 random");
      end

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule